// File: doc/BRIEF.md
# Memory Size Discovery Sequencer

This block works out how much external memory is fitted by asking a separate built-in self-test engine to check the memory at different size settings. After a start pulse it sets its size register to the smallest legal setting and sends the engine a run command. It then polls the engine until the engine reports that it has finished, and reads the engine's pass or fail bit. A failure at the smallest setting means the memory is defective. A pass moves the block on to a binary search over power-of-two size settings.

The search holds two bounds: an exponent that is known to pass and an exponent that is known to fail. The second trial uses the largest size code. The third trial uses half of that. After that, each trial uses the exponent that lies midway between the two bounds. The search stops when the two bounds are next to each other, and the block reports the passing bound as the memory size. If the engine never reports that it has finished, a poll watchdog ends the run and raises a separate flag for a hung engine. Each run ends with a one-cycle result strobe, and the result outputs keep their values until the next accepted start.

Top module: `memsize_probe`

## Requirements
- R1: After reset the block is idle. `cmd_wr`, `res_valid`, `res_defect` and `res_hung` are 0, `res_size` is 0, and `size_code` is 0x0004.
- R2: A start accepted while idle sets `size_code` to 0x0004 for the first trial. Every trial is started by exactly one single-cycle `cmd_wr` with `cmd_byte` = 0x28. This byte is the top byte (bits 63:56) of the engine's control word, and it means run with stop-on-first-failure.
- R3: `eng_done` and `eng_err` are sampled only from the cycle after `cmd_wr`. `size_code` does not change while a trial is pending.
- R4: If the trial at 0x0004 reports an error, the run ends with `res_defect` = 1 and `res_size` = 0. No further trial is issued.
- R5: The second trial uses `size_code` 0x8000. If it passes, 0x8000 is reported.
- R6: If the 0x8000 trial fails, the third trial is 0x4000. Each later trial is 2^floor((lo+hi)/2), where lo is the exponent known to pass and hi is the exponent known to fail. For example, when the memory is 0x2000, the fourth trial is 0x0100.
- R7: Every `size_code` is a power of two from 0x0004 to 0x8000. When the pass/fail outcome is monotonic in size, the reported size is the largest power of two that passes, and both `res_defect` and `res_hung` are 0.
- R8: If `eng_done` has not risen within TIMEOUT_CYC polling cycles, the run ends with `res_hung` = 1, `res_defect` = 0 and `res_size` = 0.
- R9: `res_valid` is high for exactly one cycle per run. The result outputs hold until the next accepted start, which clears them.
- R10: A `start` that arrives while a run is in progress has no effect on the trial sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a discovery run when idle |
| cmd_wr | output | 1 | Single-cycle write of the command byte to the self-test engine |
| cmd_byte | output | 8 | Command byte (0x28, run with stop-on-first-failure) |
| eng_done | input | 1 | Self-test engine finished flag |
| eng_err | input | 1 | Self-test engine error flag, valid with eng_done |
| size_code | output | 16 | Size register value for the current trial (power of two) |
| res_size | output | 16 | Discovered size code |
| res_valid | output | 1 | One-cycle result strobe |
| res_defect | output | 1 | Memory failed at the minimum size |
| res_hung | output | 1 | Self-test engine never finished |

## Verification
Two situations are hard to reach from the ports. One is a hung engine, which never raises its finished flag. The other is a start pulse that lands in the middle of a run. The bench's engine model has a hang mode that ignores commands, so the run has to sit out the full poll watchdog. A separate run holds `start` high through every poll cycle, and its trial count and result are then compared with an undisturbed run at the same memory size. A table of true memory sizes drives the search down its different paths. These include an immediate pass at the largest code, the half-size third trial, sizes that are not a power of two, and the smallest legal memory.

// File: rtl/msp_pkg.sv
package msp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_POLL  = 2'd2
    } msp_state_e;

    localparam logic [7:0] CMD_RUN_STOPFAIL = 8'h28;
endpackage

// File: rtl/msp_timeout.sv
module msp_timeout #(
    parameter int LIMIT = 1024,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == CNT_W'(LIMIT - 1));
        if (!run)
            cnt_d = '0;
        else if (expired)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT - 1));
endmodule

// File: rtl/msp_bisect.sv
module msp_bisect #(
    parameter int MIN_EXP = 2,
    parameter int MAX_EXP = 15,
    parameter int EXP_W   = 5
) (
    input  logic             first,
    input  logic             err,
    input  logic [EXP_W-1:0] lo,
    input  logic [EXP_W-1:0] hi,
    input  logic [EXP_W-1:0] trial,
    output logic [EXP_W-1:0] lo_n,
    output logic [EXP_W-1:0] hi_n,
    output logic [EXP_W-1:0] trial_n,
    output logic             finish,
    output logic             defect
);
    logic [EXP_W:0] span_sum;

    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        trial_n  = trial;
        finish   = 1'b0;
        defect   = 1'b0;
        span_sum = '0;
        if (first) begin
            if (err) begin
                finish = 1'b1;
                defect = 1'b1;
            end else begin
                trial_n = EXP_W'(MAX_EXP);
            end
        end else begin
            if (err) hi_n = trial;
            else     lo_n = trial;
            finish   = (hi_n == lo_n + 1'b1);
            span_sum = {1'b0, lo_n} + {1'b0, hi_n};
            if (lo_n == EXP_W'(MIN_EXP) && hi_n == EXP_W'(MAX_EXP))
                trial_n = EXP_W'(MAX_EXP - 1);
            else
                trial_n = span_sum[EXP_W:1];
        end
    end
endmodule

// File: rtl/memsize_probe.sv
module memsize_probe
    import msp_pkg::*;
#(
    parameter int MIN_EXP     = 2,
    parameter int MAX_EXP     = 15,
    parameter int TIMEOUT_CYC = 1024,
    localparam int SIZE_W = MAX_EXP + 1,
    localparam int EXP_W  = $clog2(MAX_EXP + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cmd_wr,
    output logic [7:0]        cmd_byte,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic [SIZE_W-1:0] size_code,
    output logic [SIZE_W-1:0] res_size,
    output logic              res_valid,
    output logic              res_defect,
    output logic              res_hung
);
    typedef struct packed {
        msp_state_e        st;
        logic [EXP_W-1:0]  lo;
        logic [EXP_W-1:0]  hi;
        logic [EXP_W-1:0]  trial;
        logic              first;
        logic [SIZE_W-1:0] size;
        logic              valid;
        logic              defect;
        logic              hung;
    } probe_regs_t;

    probe_regs_t r_d, r_q;

    logic [EXP_W-1:0] b_lo_n, b_hi_n, b_trial_n;
    logic             b_finish, b_defect;
    logic             poll_expired;

    msp_bisect #(
        .MIN_EXP (MIN_EXP),
        .MAX_EXP (MAX_EXP),
        .EXP_W   (EXP_W)
    ) u_bisect (
        .first   (r_q.first),
        .err     (eng_err),
        .lo      (r_q.lo),
        .hi      (r_q.hi),
        .trial   (r_q.trial),
        .lo_n    (b_lo_n),
        .hi_n    (b_hi_n),
        .trial_n (b_trial_n),
        .finish  (b_finish),
        .defect  (b_defect)
    );

    msp_timeout #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == ST_POLL && !eng_done),
        .expired (poll_expired)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_ISSUE;
                    r_d.trial  = EXP_W'(MIN_EXP);
                    r_d.lo     = EXP_W'(MIN_EXP);
                    r_d.hi     = EXP_W'(MAX_EXP + 1);
                    r_d.first  = 1'b1;
                    r_d.size   = '0;
                    r_d.defect = 1'b0;
                    r_d.hung   = 1'b0;
                end
            end
            ST_ISSUE: r_d.st = ST_POLL;
            ST_POLL: begin
                if (eng_done) begin
                    r_d.lo    = b_lo_n;
                    r_d.hi    = b_hi_n;
                    r_d.first = 1'b0;
                    if (b_finish) begin
                        r_d.st     = ST_IDLE;
                        r_d.valid  = 1'b1;
                        r_d.defect = b_defect;
                        r_d.size   = b_defect ? '0 : (SIZE_W'(1) << b_lo_n);
                    end else begin
                        r_d.trial = b_trial_n;
                        r_d.st    = ST_ISSUE;
                    end
                end else if (poll_expired) begin
                    r_d.st    = ST_IDLE;
                    r_d.valid = 1'b1;
                    r_d.hung  = 1'b1;
                    r_d.size  = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.lo     <= EXP_W'(MIN_EXP);
            r_q.hi     <= EXP_W'(MAX_EXP + 1);
            r_q.trial  <= EXP_W'(MIN_EXP);
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_wr     = (r_q.st == ST_ISSUE);
    assign cmd_byte   = CMD_RUN_STOPFAIL;
    assign size_code  = SIZE_W'(1) << r_q.trial;
    assign res_size   = r_q.size;
    assign res_valid  = r_q.valid;
    assign res_defect = r_q.defect;
    assign res_hung   = r_q.hung;

    // R2
    cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr);

    // R3
    size_held_in_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POLL) |-> $stable(size_code));

    // R7
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(size_code) == 1) && (size_code >= SIZE_W'(1) << MIN_EXP));

    // R7
    bounds_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lo < r_q.hi);

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_defect, res_hung}) <= 1);

    // R10
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.st == ST_POLL && !eng_done) |=> (r_q.st == ST_POLL || r_q.st == ST_IDLE));
endmodule

// File: tb/memsize_probe_tb.sv
module memsize_probe_tb;
    localparam int TIMEOUT_CYC = 1024;
    localparam int LAT = 3;
    localparam int NVEC = 8;
    // {true memory size, expected reported size}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h8000, 16'h8000}, {16'h4000, 16'h4000}, {16'h2000, 16'h2000},
        {16'h3000, 16'h2000}, {16'h0010, 16'h0010}, {16'h0008, 16'h0008},
        {16'h0004, 16'h0004}, {16'hFFFF, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_wr;
    logic [7:0]  cmd_byte;
    logic        eng_done, eng_err;
    logic [15:0] size_code, res_size;
    logic        res_valid, res_defect, res_hung;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    memsize_probe #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .eng_done(eng_done), .eng_err(eng_err),
        .size_code(size_code), .res_size(res_size),
        .res_valid(res_valid), .res_defect(res_defect), .res_hung(res_hung)
    );

    // Behavioural self-test engine
    logic [15:0] true_size = 16'h0;
    logic        hang_mode = 1'b0;
    logic        log_clr = 1'b0;
    logic        eng_busy = 1'b0;
    int          eng_cnt = 0;
    int          ntr = 0;
    logic [15:0] trial_log [32];
    logic        bad_cmd = 1'b0;
    logic        dbl_cmd = 1'b0;
    logic        prev_wr = 1'b0;

    initial begin
        eng_done = 1'b0;
        eng_err  = 1'b0;
    end

    always @(posedge clk) begin
        prev_wr <= cmd_wr;
        if (log_clr) begin
            ntr     <= 0;
            bad_cmd <= 1'b0;
            dbl_cmd <= 1'b0;
        end else if (cmd_wr) begin
            if (ntr < 32) trial_log[ntr] <= size_code;
            ntr <= ntr + 1;
            if (cmd_byte != 8'h28) bad_cmd <= 1'b1;
            if (prev_wr) dbl_cmd <= 1'b1;
        end
        if (cmd_wr) begin
            eng_done <= 1'b0;
            eng_busy <= 1'b1;
            eng_cnt  <= LAT;
        end else if (eng_busy && !hang_mode) begin
            if (eng_cnt == 0) begin
                eng_done <= 1'b1;
                eng_err  <= (size_code > true_size);
                eng_busy <= 1'b0;
            end else begin
                eng_cnt <= eng_cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int          run_cycles;
    logic        size_moved;

    task automatic run_probe(input logic [15:0] ts, input logic hang, input logic hammer);
        logic [15:0] held;
        true_size = ts;
        hang_mode = hang;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = hammer;
        run_cycles = 0;
        size_moved = 1'b0;
        held = size_code;
        while (!res_valid && run_cycles < 20000) begin
            @(negedge clk);
            run_cycles++;
            if (eng_busy && size_code != held) size_moved = 1'b1;
            if (cmd_wr) held = size_code;
        end
        start = 1'b0;
    endtask

    function automatic logic legal_size(input logic [15:0] s);
        return ($countones(s) == 1) && (s >= 16'h0004);
    endfunction

    initial begin
        int ref_ntr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cmd_wr", cmd_wr, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 flags", {res_defect, res_hung}, 0);
        chk("R1 res_size", res_size, 0);
        chk("R1 size_code", size_code, 16'h0004);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] ts, ex;
            logic all_legal;
            ts = VEC[i][31:16];
            ex = VEC[i][15:0];
            run_probe(ts, 1'b0, 1'b0);
            chk("R7 result size", res_size, ex);
            chk("R7 no flags", {res_defect, res_hung}, 0);
            chk("R2 first trial", trial_log[0], 16'h0004);
            chk("R5 second trial", trial_log[1], 16'h8000);
            chk("R2 command byte", bad_cmd, 0);
            chk("R2 single cmd pulse", dbl_cmd, 0);
            chk("R3 size held", size_moved, 0);
            if (ts < 16'h8000) chk("R6 third trial", trial_log[2], 16'h4000);
            else               chk("R5 two trials", ntr, 2);
            all_legal = 1'b1;
            for (int k = 0; k < ntr && k < 32; k++)
                if (!legal_size(trial_log[k])) all_legal = 1'b0;
            chk("R7 legal trials", all_legal, 1);
            if (ts == 16'h2000) chk("R6 midpoint trial", trial_log[3], 16'h0100);
            // R9 valid one cycle, held result
            @(negedge clk);
            chk("R9 valid drops", res_valid, 0);
            chk("R9 result held", res_size, ex);
        end

        // R4 defective memory
        run_probe(16'h0000, 1'b0, 1'b0);
        chk("R4 defect flag", res_defect, 1);
        chk("R4 size zero", res_size, 0);
        chk("R4 one trial", ntr, 1);
        chk("R4 not hung", res_hung, 0);

        // R9 hold then clear on start
        repeat (10) @(negedge clk);
        chk("R9 defect held", res_defect, 1);
        true_size = 16'h4000;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 cleared on start", res_defect, 0);
        while (!res_valid) @(negedge clk);
        chk("R9 next run size", res_size, 16'h4000);

        // R8 hung engine
        run_probe(16'h4000, 1'b1, 1'b0);
        chk("R8 hung flag", res_hung, 1);
        chk("R8 no defect", res_defect, 0);
        chk("R8 size zero", res_size, 0);
        chk("R8 waited timeout", run_cycles >= TIMEOUT_CYC, 1);
        hang_mode = 1'b0;

        // R10 start held during a run
        run_probe(16'h2000, 1'b0, 1'b0);
        ref_ntr = ntr;
        run_probe(16'h2000, 1'b0, 1'b1);
        chk("R10 result", res_size, 16'h2000);
        chk("R10 trial count", ntr, ref_ntr);
        chk("R10 first trial", trial_log[0], 16'h0004);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule